// File: doc/BRIEF.md
# Bus Search Direction Step

This block carries out one bit position of the enumeration walk that a single-wire bus controller runs to discover the 64-bit identities of the devices on its line. When started, it asks a separate slot-timing master for two read slots. The first slot samples the identity bit that every still-participating device drives. The second slot samples the complement of that bit. From these two samples and a preferred direction supplied by the caller, the block picks the branch to follow. It then writes that branch back onto the bus in a third slot, so that devices whose bit differs drop out of the walk.

The slot master is reached over a simple request/acknowledge interface. The block raises a request together with the value to drive, a 1 for a read slot or the direction bit for the write. It holds both steady until the master returns a one-cycle acknowledge carrying the level it sampled. The caller sees a single done pulse and a 3-bit status code. The code tells the caller whether the position showed no conflict, a genuine branch, or an empty bus. In the empty-bus case the walk must be started over.

Top module: `rom_search_step`

## Requirements
- R1: After reset the block is idle: busy, done and slot_req are 0 and result is 3'b000.
- R2: A start pulse while idle makes the block request a slot in the next cycle with slot_wval = 1, the identity-bit read.
- R3: After the first slot is acknowledged, a second slot is requested with slot_wval = 1, the complement-bit read.
- R4: If both sampled bits are 1, result becomes 3'b011, done pulses and no third slot is requested.
- R5: If both sampled bits are 0, the direction is the pref_dir value captured at start; result is 3'b100 for direction 1 and 3'b000 for direction 0.
- R6: If exactly one sampled bit is 1, the direction equals the identity bit; result is 3'b101 when the identity bit is 1 and 3'b010 when the complement bit is 1.
- R7: Result field layout: bit 0 is the identity bit, bit 1 the complement bit, bit 2 the direction written, which is 0 on error.
- R8: Outside the error case, a third slot is requested with slot_wval equal to the chosen direction. done is high for exactly one cycle per step, in the cycle after the last acknowledged slot, and busy is 0 in that cycle.
- R9: start is ignored while busy: it neither restarts the step nor adds slots.
- R10: pref_dir is sampled only on the accepted start; later changes have no effect on the step.
- R11: Once slot_req is raised it stays high with an unchanged slot_wval until slot_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one search step (accepted when idle) |
| pref_dir | input | 1 | Direction to take when both samples are 0 |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 3 | {direction, complement bit, identity bit} |
| slot_req | output | 1 | Slot request to the timing master |
| slot_wval | output | 1 | Value to drive in the requested slot |
| slot_ack | input | 1 | One-cycle slot completion from the master |
| slot_rbit | input | 1 | Level sampled during the acknowledged slot |

## Verification
The assertions take for granted that slot_ack only pulses while slot_req is high and lasts one cycle, and that start is a clean synchronous pulse. The bench's slot master model acknowledges only a pending request, after a random delay of zero to three cycles, and drops the acknowledge on the following cycle. It answers each slot from bit values chosen for that step. Start is also pulsed at random points while the block is busy, and pref_dir is inverted right after each accepted start, so the ignore and capture rules are exercised on every step.

// File: rtl/trip_pkg.sv
// Package: shared state type and result layout for the search step.
// Assumes: result width is fixed by the three fields it carries.
package trip_pkg;
    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ID   = 2'd1,
        ST_CMP  = 2'd2,
        ST_DIR  = 2'd3
    } trip_state_t;

    // Field order matters: the caller decodes bit 0 = id, 1 = cmp, 2 = dir.
    typedef struct packed {
        logic dir;
        logic cmp;
        logic id;
    } trip_code_t;
endpackage

// File: rtl/trip_choose.sv
// Module: trip_choose
// Picks the branch from the two sampled bits and the preferred direction.
// Assumes: inputs are registered values; purely combinational.
module trip_choose (
    input  logic id_bit,
    input  logic cmp_bit,
    input  logic pref,
    output logic dir,
    output logic conflict
);
    // Decide direction: a lone 1 wins, otherwise fall back to preference.
    always_comb begin
        conflict = id_bit & cmp_bit;
        if (id_bit ^ cmp_bit)
            dir = id_bit;
        else
            dir = pref & ~conflict;
    end
endmodule

// File: rtl/trip_seq.sv
// Module: trip_seq
// Walks the three slots of one step and drives the slot request.
// Assumes: slot_ack is a one-cycle pulse given only while slot_req is high.
module trip_seq
    import trip_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pref_dir,
    input  logic slot_ack,
    input  logic slot_rbit,
    input  logic dir,
    output logic busy,
    output logic slot_req,
    output logic slot_wval,
    output logic id_q,
    output logic cmp_q,
    output logic pref_q,
    output logic fin_ok,
    output logic fin_err
);
    trip_state_t state;

    // State advance and sample capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            id_q   <= 1'b0;
            cmp_q  <= 1'b0;
            pref_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    pref_q <= pref_dir;
                    state  <= ST_ID;
                end
                ST_ID: if (slot_ack) begin
                    id_q  <= slot_rbit;
                    state <= ST_CMP;
                end
                ST_CMP: if (slot_ack) begin
                    cmp_q <= slot_rbit;
                    state <= (id_q & slot_rbit) ? ST_IDLE : ST_DIR;
                end
                ST_DIR: if (slot_ack) begin
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Slot request, drive value and completion strobes.
    always_comb begin
        busy      = (state != ST_IDLE);
        slot_req  = busy;
        slot_wval = (state == ST_DIR) ? dir : 1'b1;
        fin_ok    = (state == ST_DIR) & slot_ack;
        fin_err   = (state == ST_CMP) & slot_ack & id_q & slot_rbit;
    end
endmodule

// File: rtl/trip_out.sv
// Module: trip_out
// Registers the status code and the done pulse.
// Assumes: fin_ok and fin_err are never high together.
module trip_out
    import trip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fin_ok,
    input  logic              fin_err,
    input  logic              dir,
    input  logic              id_q,
    input  logic              cmp_q,
    output logic              done,
    output logic [CODE_W-1:0] result
);
    trip_code_t code_q;

    // Load the code on completion and raise done for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= '0;
            done   <= 1'b0;
        end else begin
            done <= fin_ok | fin_err;
            if (fin_err)
                code_q <= '{dir: 1'b0, cmp: 1'b1, id: 1'b1};
            else if (fin_ok)
                code_q <= '{dir: dir, cmp: cmp_q, id: id_q};
        end
    end

    assign result = code_q;
endmodule

// File: rtl/rom_search_step.sv
// Module: rom_search_step
// One bit position of the bus identity search: read id, read complement,
// choose and write the branch. Slot timing lives in an external master.
// Assumes: start is a synchronous pulse; slot_ack follows the request rules.
module rom_search_step
    import trip_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pref_dir,
    output logic              busy,
    output logic              done,
    output logic [CODE_W-1:0] result,
    output logic              slot_req,
    output logic              slot_wval,
    input  logic              slot_ack,
    input  logic              slot_rbit
);
    logic id_q, cmp_q, pref_q, dir, conflict, fin_ok, fin_err;
    logic unused_conflict;

    trip_seq u_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
        .slot_ack(slot_ack), .slot_rbit(slot_rbit), .dir(dir),
        .busy(busy), .slot_req(slot_req), .slot_wval(slot_wval),
        .id_q(id_q), .cmp_q(cmp_q), .pref_q(pref_q),
        .fin_ok(fin_ok), .fin_err(fin_err)
    );

    trip_choose u_choose (
        .id_bit(id_q), .cmp_bit(cmp_q), .pref(pref_q),
        .dir(dir), .conflict(conflict)
    );

    trip_out u_out (
        .clk(clk), .rst_n(rst_n), .fin_ok(fin_ok), .fin_err(fin_err),
        .dir(dir), .id_q(id_q), .cmp_q(cmp_q),
        .done(done), .result(result)
    );

    // Conflict is decided in the sequencer from the live sample.
    assign unused_conflict = conflict;
endmodule

// File: rtl/trip_checker.sv
// Module: trip_checker
// Temporal properties of the search step, bound to the top module.
// Assumes: slot_ack pulses only while a request is pending.
module trip_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       done,
    input logic [2:0] result,
    input logic       slot_req,
    input logic       slot_wval,
    input logic       slot_ack
);
    p_start_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (slot_req && slot_wval));

    p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_req && !slot_ack) |=> (slot_req && $stable(slot_wval)));

    p_err_nodir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result[1:0] == 2'b11) |-> !result[2]);

    p_single_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (result[0] ^ result[1])) |-> (result[2] == result[0]));

    p_done_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !slot_ack) |=> busy);
endmodule

bind rom_search_step trip_checker u_trip_checker (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .result(result), .slot_req(slot_req), .slot_wval(slot_wval),
    .slot_ack(slot_ack)
);

// File: tb/test_rom_search_step.sv
module test_rom_search_step;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       pref_dir = 1'b0;
    logic       busy, done, slot_req, slot_wval;
    logic [2:0] result;
    logic       slot_ack = 1'b0;
    logic       slot_rbit = 1'b0;

    int n_chk = 0;
    int n_bad = 0;

    // Slave bits for the step and log of driven slot values.
    logic id_v = 1'b0, cmp_v = 1'b0;
    int   nslots = 0;
    logic wlog [0:3];

    always #2 clk = ~clk;

    rom_search_step i_rom_search_step (
        .clk(clk), .rst_n(rst_n), .start(start), .pref_dir(pref_dir),
        .busy(busy), .done(done), .result(result),
        .slot_req(slot_req), .slot_wval(slot_wval),
        .slot_ack(slot_ack), .slot_rbit(slot_rbit)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [2:0] exp_code(input logic id, input logic cmp, input logic pref);
        if (id && cmp)      return 3'b011;
        else if (id ^ cmp)  return {id, cmp, id};
        else                return {pref, 2'b00};
    endfunction

    // Slot master model: acknowledge each pending request after 0..3 cycles.
    initial begin
        forever begin
            @(negedge clk);
            slot_ack = 1'b0;
            if (slot_req) begin
                repeat ($urandom % 4) @(negedge clk);
                if (nslots < 4) wlog[nslots] = slot_wval;
                slot_rbit = (nslots == 0) ? id_v : (nslots == 1) ? cmp_v : 1'b0;
                nslots++;
                slot_ack = 1'b1;
            end
        end
    end

    task automatic run_step(input logic id, input logic cmp, input logic pref, input bit poke);
        logic [2:0] e;
        int waited;
        int nexp;
        id_v = id; cmp_v = cmp; nslots = 0;
        e = exp_code(id, cmp, pref);
        nexp = (id && cmp) ? 2 : 3;
        @(negedge clk);
        start = 1'b1; pref_dir = pref;
        @(negedge clk);
        start = 1'b0; pref_dir = ~pref;   // R10: later change must not matter
        check(slot_req === 1'b1 && slot_wval === 1'b1, "R2", int'(slot_wval), 1);
        waited = 0;
        while (done !== 1'b1 && waited < 100) begin
            if (poke && waited == 2) start = 1'b1;   // R9: start while busy
            @(negedge clk);
            start = 1'b0;
            waited++;
        end
        check(done === 1'b1, "R8 done seen", int'(done), 1);
        check(busy === 1'b0, "R8 idle at done", int'(busy), 0);
        check(result === e, (id && cmp) ? "R4 code" : (id ^ cmp) ? "R6 code" : "R5 R10 code",
              int'(result), int'(e));
        check(nslots == nexp, (id && cmp) ? "R4 slot count" : "R8 slot count", nslots, nexp);
        check(wlog[1] === 1'b1, "R3 second slot reads", int'(wlog[1]), 1);
        if (nexp == 3)
            check(wlog[2] === e[2], "R8 R7 direction written", int'(wlog[2]), int'(e[2]));
        @(negedge clk);
        check(done === 1'b0, "R8 single pulse", int'(done), 0);
        repeat (4) @(negedge clk);
        check(busy === 1'b0 && nslots == nexp, "R9 no extra slots", nslots, nexp);
    endtask

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        process::self().srandom(32'd7);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && slot_req === 1'b0, "R1 idle", int'(busy), 0);
        check(result === 3'b000, "R1 result", int'(result), 0);
        // Directed corners.
        run_step(1'b1, 1'b1, 1'b1, 1'b0);
        run_step(1'b0, 1'b0, 1'b1, 1'b0);
        run_step(1'b0, 1'b0, 1'b0, 1'b1);
        run_step(1'b1, 1'b0, 1'b0, 1'b0);
        run_step(1'b0, 1'b1, 1'b1, 1'b1);
        run_step(1'b1, 1'b1, 1'b0, 1'b1);
        // Random mix.
        for (int k = 0; k < 40; k++)
            run_step(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule